// File: doc/BRIEF.md
# Event-Triggered Timestamp Capture Unit

The block keeps a free-running time base and, for each of several independent channels, latches the current time value when that channel's event input rises. Typical event sources are interrupt lines from bus controllers, so firmware can later learn when each event happened without servicing it at once.

Each channel has a status word and a read-only snapshot word, reached through a simple 32-bit register port with a combinational read path and a one-cycle write strobe. The status word carries a sticky "snapshot waiting" flag and a sticky "snapshot lost" flag. A capture that arrives while an earlier snapshot is still unread overwrites it and raises the loss flag. Both flags clear only when software writes a one to their bit.

The channel count, time width, register window base, per-channel stride and snapshot offset are parameters. They are checked when the design is elaborated.

Top module: `tsc_capture_top`

## Requirements
- R1: After reset every status word reads 0, every snapshot word reads 0, and the time base starts at 0.
- R2: The time base adds one on every clock after reset and wraps modulo 2^TIME_W. The value captured is the time base value at the clock edge where the rising edge of the event is sampled.
- R3: A low-to-high change on a channel's event input loads the time into that channel's snapshot and sets its valid flag (status bit 0). An input held high for many cycles causes exactly one capture.
- R4: The valid flag stays set until a write to the channel's status address with bit 0 set. Writes with bit 0 clear leave it unchanged.
- R5: A capture while the valid flag is set raises the overrun flag (status bit 1) and replaces the snapshot with the new time.
- R6: The overrun flag is cleared only by a write to the status address with bit 1 set. Clearing valid alone leaves it set.
- R7: When a valid-clearing write and a capture fall in the same cycle, the capture wins. Valid stays 1, overrun is not raised, and the snapshot takes the new time.
- R8: Channel n's status sits at byte address BASE + n*STRIDE (defaults 0x140, stride 0x10). Its snapshot sits at that address + SNAP_OFS (default 0x4), read-only and zero-extended to 32 bits. Status bits 31..2 read 0.
- R9: Reads of any address not listed in R8 return 0. Writes to such addresses, and writes to snapshot addresses, change no state.
- R10: Channels are independent. An event or a write on one channel leaves the other channel's status and snapshot untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| evt_i | input | NUM_CH | Per-channel event inputs, rising edge captures |
| reg_addr | input | ADDR_W | Register byte address |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr, combinational |

## Verification
The bench builds the block with two channels, the default register map and TIME_W set to 8. With that width the time base wraps every 256 cycles, so a capture just before the wrap and another just after it can be checked directly. The narrow time field also exercises the zero-extension variant of the read path. A reference time counter in the bench gives the expected snapshot value for every capture, including captures that coincide with flag-clearing writes.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
   localparam int STAT_VALID_BIT = 0;
   localparam int STAT_OVR_BIT   = 1;
   localparam int STAT_W         = 2;

   typedef struct packed {
      logic ovr;
      logic valid;
   } tsc_flags_t;

   function automatic int ch_status_addr(input int base, input int stride, input int ch);
      return base + ch * stride;
   endfunction
endpackage

// File: rtl/tsc_time_base.sv
module tsc_time_base #(
   parameter int TIME_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [TIME_W-1:0] time_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) time_o <= '0;
      else        time_o <= time_o + 1'b1;
   end

   // R2: one step per clock, modulo the width
   a_r2_time_step: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> time_o == $past(time_o) + 1'b1);
endmodule

// File: rtl/tsc_channel.sv
module tsc_channel
   import tsc_pkg::*;
#(
   parameter int TIME_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_i,
   input  logic [TIME_W-1:0] time_i,
   input  logic              clr_valid_i,
   input  logic              clr_ovr_i,
   output tsc_flags_t        flags_o,
   output logic [TIME_W-1:0] snap_o
);
   logic evt_q;
   logic cap;
   tsc_flags_t flags_d;

   always_ff @(posedge clk) begin
      if (!rst_n) evt_q <= 1'b0;
      else        evt_q <= evt_i;
   end

   assign cap = evt_i & ~evt_q;

   always_comb begin
      flags_d.valid = cap | (flags_o.valid & ~clr_valid_i);
      flags_d.ovr   = (flags_o.ovr & ~clr_ovr_i)
                    | (cap & flags_o.valid & ~clr_valid_i);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags_o <= '0;
         snap_o  <= '0;
      end else begin
         flags_o <= flags_d;
         if (cap) snap_o <= time_i;
      end
   end

   a_r3_capture_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
      cap |=> flags_o.valid);
   a_r3_snap_takes_time: assert property (@(posedge clk) disable iff (!rst_n)
      cap |=> snap_o == $past(time_i));
   a_r3_snap_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !cap |=> $stable(snap_o));
   a_r3_held_level_once: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i && $past(evt_i) |-> !cap);
   a_r4_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      flags_o.valid && !clr_valid_i |=> flags_o.valid);
   a_r5_overrun_raised: assert property (@(posedge clk) disable iff (!rst_n)
      cap && flags_o.valid && !clr_valid_i |=> flags_o.ovr);
   a_r6_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      flags_o.ovr && !clr_ovr_i |=> flags_o.ovr);
   a_r7_capture_wins: assert property (@(posedge clk) disable iff (!rst_n)
      cap && clr_valid_i && !flags_o.ovr |=> flags_o.valid && !flags_o.ovr);
endmodule

// File: rtl/tsc_reg_decode.sv
module tsc_reg_decode
   import tsc_pkg::*;
#(
   parameter int NUM_CH   = 2,
   parameter int ADDR_W   = 12,
   parameter int DATA_W   = 32,
   parameter int TIME_W   = 32,
   parameter int BASE     = 'h140,
   parameter int STRIDE   = 'h10,
   parameter int SNAP_OFS = 'h4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [ADDR_W-1:0]             addr_i,
   input  logic                          we_i,
   input  logic [STAT_W-1:0]             wbits_i,
   input  tsc_flags_t [NUM_CH-1:0]       flags_i,
   input  logic [NUM_CH-1:0][TIME_W-1:0] snap_i,
   output logic [NUM_CH-1:0]             clr_valid_o,
   output logic [NUM_CH-1:0]             clr_ovr_o,
   output logic [DATA_W-1:0]             rdata_o
);
   logic [NUM_CH-1:0]             st_hit;
   logic [NUM_CH-1:0]             sn_hit;
   logic [NUM_CH-1:0][DATA_W-1:0] snap_ext;
   logic [NUM_CH-1:0][DATA_W-1:0] stat_ext;

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      localparam int ST_ADDR = ch_status_addr(BASE, STRIDE, ch);
      localparam int SN_ADDR = ST_ADDR + SNAP_OFS;

      assign st_hit[ch] = (addr_i == ADDR_W'(ST_ADDR));
      assign sn_hit[ch] = (addr_i == ADDR_W'(SN_ADDR));

      assign clr_valid_o[ch] = we_i & st_hit[ch] & wbits_i[STAT_VALID_BIT];
      assign clr_ovr_o[ch]   = we_i & st_hit[ch] & wbits_i[STAT_OVR_BIT];

      assign stat_ext[ch] = {{(DATA_W-STAT_W){1'b0}}, flags_i[ch]};

      if (TIME_W == DATA_W) begin : g_full
         assign snap_ext[ch] = snap_i[ch];
      end else begin : g_zext
         assign snap_ext[ch] = {{(DATA_W-TIME_W){1'b0}}, snap_i[ch]};
      end
   end

   always_comb begin
      rdata_o = '0;
      for (int ch = 0; ch < NUM_CH; ch++) begin
         if (st_hit[ch]) rdata_o = rdata_o | stat_ext[ch];
         if (sn_hit[ch]) rdata_o = rdata_o | snap_ext[ch];
      end
   end

   a_r8_single_select: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({st_hit, sn_hit}));
   a_r8_status_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (|st_hit) |-> rdata_o[DATA_W-1:STAT_W] == '0);
   a_r9_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !(|st_hit) && !(|sn_hit) |-> rdata_o == '0);
   a_r9_no_clear_off_status: assert property (@(posedge clk) disable iff (!rst_n)
      !(|st_hit) |-> clr_valid_o == '0 && clr_ovr_o == '0);
endmodule

// File: rtl/tsc_capture_top.sv
module tsc_capture_top
   import tsc_pkg::*;
#(
   parameter int NUM_CH   = 2,
   parameter int TIME_W   = 32,
   parameter int ADDR_W   = 12,
   parameter int DATA_W   = 32,
   parameter int BASE     = 'h140,
   parameter int STRIDE   = 'h10,
   parameter int SNAP_OFS = 'h4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] evt_i,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_we,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata
);
   localparam int MAP_END = BASE + NUM_CH * STRIDE;

   if (NUM_CH < 1) begin : g_bad_ch
      $error("NUM_CH must be at least 1");
   end
   if (TIME_W < 1 || TIME_W > DATA_W) begin : g_bad_time
      $error("TIME_W must lie in 1..DATA_W");
   end
   if (DATA_W < STAT_W + 1) begin : g_bad_data
      $error("DATA_W too narrow for the status word");
   end
   if (SNAP_OFS <= 0 || SNAP_OFS >= STRIDE || (SNAP_OFS % 4) != 0) begin : g_bad_ofs
      $error("SNAP_OFS must be word aligned and inside the channel window");
   end
   if (MAP_END > (1 << ADDR_W)) begin : g_bad_map
      $error("register window does not fit in ADDR_W");
   end

   logic [TIME_W-1:0]             sys_time;
   tsc_flags_t [NUM_CH-1:0]       flags;
   logic [NUM_CH-1:0][TIME_W-1:0] snaps;
   logic [NUM_CH-1:0]             clr_valid;
   logic [NUM_CH-1:0]             clr_ovr;
   logic                          wdata_unused;

   assign wdata_unused = ^reg_wdata[DATA_W-1:STAT_W];

   tsc_time_base #(.TIME_W(TIME_W)) time_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .time_o (sys_time)
   );

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
      tsc_channel #(.TIME_W(TIME_W)) chan_i (
         .clk         (clk),
         .rst_n       (rst_n),
         .evt_i       (evt_i[ch]),
         .time_i      (sys_time),
         .clr_valid_i (clr_valid[ch]),
         .clr_ovr_i   (clr_ovr[ch]),
         .flags_o     (flags[ch]),
         .snap_o      (snaps[ch])
      );
   end

   tsc_reg_decode #(
      .NUM_CH   (NUM_CH),
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .TIME_W   (TIME_W),
      .BASE     (BASE),
      .STRIDE   (STRIDE),
      .SNAP_OFS (SNAP_OFS)
   ) dec_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .addr_i      (reg_addr),
      .we_i        (reg_we),
      .wbits_i     (reg_wdata[STAT_W-1:0]),
      .flags_i     (flags),
      .snap_i      (snaps),
      .clr_valid_o (clr_valid),
      .clr_ovr_o   (clr_ovr),
      .rdata_o     (reg_rdata)
   );

   // R10: a clear aimed at one channel never reaches two at once
   a_r10_one_channel_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(clr_valid | clr_ovr));
endmodule

// File: tb/tsc_capture_top_tb_top.sv
module tsc_capture_top_tb_top;
   localparam int NUM_CH = 2;
   localparam int TIME_W = 8;
   localparam int ADDR_W = 12;
   localparam int DATA_W = 32;

   localparam logic [ADDR_W-1:0] ST0 = 12'h140;
   localparam logic [ADDR_W-1:0] SN0 = 12'h144;
   localparam logic [ADDR_W-1:0] ST1 = 12'h150;
   localparam logic [ADDR_W-1:0] SN1 = 12'h154;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NUM_CH-1:0] evt = '0;
   logic [ADDR_W-1:0] addr = '0;
   logic              we = 1'b0;
   logic [DATA_W-1:0] wdata = '0;
   logic [DATA_W-1:0] rdata;

   logic [TIME_W-1:0] tb_time;
   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) tb_time <= '0;
      else        tb_time <= tb_time + 1'b1;
   end

   tsc_capture_top #(.NUM_CH(NUM_CH), .TIME_W(TIME_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_i     (evt),
      .reg_addr  (addr),
      .reg_we    (we),
      .reg_wdata (wdata),
      .reg_rdata (rdata)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic do_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic do_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
      @(negedge clk);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic rd_chk(input string req, input logic [ADDR_W-1:0] a, input logic [31:0] exp);
      logic [31:0] d;
      do_read(a, d);
      chk(req, d, exp);
   endtask

   task automatic pulse(input int ch, output logic [31:0] exp);
      @(negedge clk);
      evt[ch] = 1'b1;
      exp = 32'(tb_time);
      @(negedge clk);
      evt[ch] = 1'b0;
   endtask

   task automatic t_reset();
      rd_chk("R1 status0", ST0, 0);
      rd_chk("R1 snap0",   SN0, 0);
      rd_chk("R1 status1", ST1, 0);
      rd_chk("R1 snap1",   SN1, 0);
   endtask

   task automatic t_capture();
      logic [31:0] e;
      pulse(0, e);
      rd_chk("R3 valid set", ST0, 1);
      rd_chk("R2 R3 snap time", SN0, e);
      do_write(ST0, 1);
      repeat (7) @(negedge clk);
      pulse(0, e);
      rd_chk("R2 later snap time", SN0, e);
      do_write(ST0, 1);
   endtask

   task automatic t_level();
      logic [31:0] e;
      @(negedge clk);
      evt[0] = 1'b1;
      e = 32'(tb_time);
      repeat (6) @(negedge clk);
      evt[0] = 1'b0;
      rd_chk("R3 held level single capture status", ST0, 1);
      rd_chk("R3 held level snap first edge", SN0, e);
   endtask

   task automatic t_w1c_valid();
      do_write(ST0, 0);
      rd_chk("R4 write zero keeps valid", ST0, 1);
      do_write(ST0, 32'hFFFF_FFFC);
      rd_chk("R4 bit0 clear keeps valid", ST0, 1);
      do_write(ST0, 1);
      rd_chk("R4 write one clears valid", ST0, 0);
   endtask

   task automatic t_overrun();
      logic [31:0] e1, e2;
      pulse(0, e1);
      repeat (2) @(negedge clk);
      pulse(0, e2);
      rd_chk("R5 overrun raised", ST0, 3);
      rd_chk("R5 snap replaced", SN0, e2);
      do_write(ST0, 1);
      rd_chk("R6 ovr survives valid clear", ST0, 2);
      do_write(ST0, 0);
      rd_chk("R6 ovr survives zero write", ST0, 2);
      do_write(ST0, 2);
      rd_chk("R6 ovr cleared by bit1", ST0, 0);
   endtask

   task automatic t_same_cycle();
      logic [31:0] e;
      pulse(0, e);
      @(negedge clk);
      evt[0] = 1'b1;
      e = 32'(tb_time);
      addr = ST0; wdata = 1; we = 1'b1;
      @(negedge clk);
      evt[0] = 1'b0; we = 1'b0;
      rd_chk("R7 capture wins over clear", ST0, 1);
      rd_chk("R7 snap takes new time", SN0, e);
      do_write(ST0, 3);
   endtask

   task automatic t_indep();
      logic [31:0] e0, e1, d;
      do_read(SN0, e0);
      pulse(1, e1);
      rd_chk("R10 ch1 valid", ST1, 1);
      rd_chk("R10 ch1 snap", SN1, e1);
      rd_chk("R10 ch0 status untouched", ST0, 0);
      rd_chk("R10 ch0 snap untouched", SN0, e0);
      do_write(ST0, 3);
      rd_chk("R10 ch0 write leaves ch1", ST1, 1);
      do_write(ST1, 3);
      rd_chk("R10 ch1 cleared", ST1, 0);
      do_read(SN1, d);
      chk("R10 ch1 snap kept after clear", d, e1);
   endtask

   task automatic t_undef();
      logic [31:0] e1, e2;
      pulse(0, e1);
      repeat (2) @(negedge clk);
      pulse(0, e2);
      do_write(12'h148, 32'hFFFF_FFFF);
      do_write(12'h14C, 32'hFFFF_FFFF);
      do_write(12'h141, 32'hFFFF_FFFF);
      do_write(12'h160, 32'hFFFF_FFFF);
      do_write(12'h000, 32'hFFFF_FFFF);
      rd_chk("R9 unmapped writes ignored", ST0, 3);
      do_write(SN0, 32'hFFFF_FFFF);
      rd_chk("R9 snap write ignored", SN0, e2);
      rd_chk("R9 snap write leaves status", ST0, 3);
      rd_chk("R9 read 0x148", 12'h148, 0);
      rd_chk("R9 read 0x141", 12'h141, 0);
      rd_chk("R9 read 0x160", 12'h160, 0);
      rd_chk("R9 read 0x000", 12'h000, 0);
      rd_chk("R8 ch0 status value", ST0, 3);
      do_write(ST0, 3);
   endtask

   task automatic t_wrap();
      while (tb_time != 8'd253) @(negedge clk);
      evt[0] = 1'b1;
      @(negedge clk);
      evt[0] = 1'b0;
      rd_chk("R2 capture before wrap", SN0, 253);
      do_write(ST0, 1);
      while (tb_time != 8'd0) @(negedge clk);
      evt[0] = 1'b1;
      @(negedge clk);
      evt[0] = 1'b0;
      rd_chk("R2 capture after wrap", SN0, 0);
      rd_chk("R2 wrap no overrun", ST0, 1);
      do_write(ST0, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_capture();
      t_level();
      t_w1c_valid();
      t_overrun();
      t_same_cycle();
      t_indep();
      t_undef();
      t_wrap();
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule